// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block runs a group of 8-bit general-purpose I/O ports from a simple register bus in I/O address space. Each pin is either given to an on-chip peripheral or kept under software control. A software-controlled pin can be a push-pull output, an input, or an open-drain output. A single direction bit chooses between push-pull output and the combined input/open-drain behaviour.

Each port has a mode register, a direction register and a data-latch register, all read/write, and a read-only pin-state register. The block decodes the bus address and updates the registers on a write strobe. It drives a per-pin output value and output enable toward the pads. It passes the pad inputs through a two-flop synchronizer. The synchronized value feeds both the pin-state read path and the peripheral input signals.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every mode bit is 0, every direction bit is 1 and every latch bit is 1, so `padOe` is all zeros.
- R2: Register addresses use this map (p = 0, 1, 2):
  - mode register: 0xF820 + 2*p
  - pin-state register: 0xF860 + 8*p
  - latch register: 0xF862 + 8*p
  - direction register: 0xF864 + 8*p

  A write with `busWrEn` high takes effect on the next rising clock edge. From then on, a read of a mode, direction or latch address returns the written byte.
- R3: A pin whose mode bit is 1 drives `padOut`/`padOe` straight from `perOut`/`perOe` of the same bit. Its direction and latch bits have no effect.
- R4: A pin with mode bit 0 and direction bit 0 has `padOe` = 1 and `padOut` = latch bit.
- R5: A pin with mode bit 0 and direction bit 1 has `padOe` = NOT latch bit and `padOut` = 0. A 0 in the latch drives the pin low; a 1 releases it.
- R6: A latch read returns the stored latch byte, not the pad level.
- R7: The pin-state read returns `padIn` after two rising edges of synchronization, whatever the mode and direction. `perIn` carries the same synchronized value.
- R8: A write to a pin-state address changes no register.
- R9: A read of any unmapped address returns 0. A write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| padIn | input | 24 | Pad input levels, port p in bits [8p+7:8p] |
| padOut | output | 24 | Pad output values |
| padOe | output | 24 | Pad output enables |
| perOut | input | 24 | Peripheral output values |
| perOe | input | 24 | Peripheral output enables |
| perIn | output | 24 | Synchronized pad levels toward peripherals |

## Verification
Register writes are visible on a read one edge after the strobe. Pad output value and enable follow register or peripheral changes in the same cycle. Pin-state reads and `perIn` lag `padIn` by two rising edges. The bench changes its inputs just after a rising edge. It queues each expected value and compares it at the following falling edge. For the synchronizer it checks the read after one edge, expecting the old value, and after two edges, expecting the new one.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int PORT_IDX_W = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_DIR,
    SEL_LATCH,
    SEL_PIN
  } regSel_e;

  typedef struct packed {
    regSel_e                 sel;
    logic [PORT_IDX_W-1:0]   portIdx;
    logic                    wrStrobe;
  } busCmd_t;
endpackage

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 16,
  parameter int MODE_BASE = 'hF820,
  parameter int MODE_STEP = 2,
  parameter int BANK_BASE = 'hF860,
  parameter int BANK_STEP = 8,
  parameter int LATCH_OFS = 2,
  parameter int DIR_OFS   = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busCmd_t           cmd
);
  logic [NUM_PORTS-1:0] modeHit, dirHit, latchHit, pinHit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign modeHit[p]  = busAddr == ADDR_W'(MODE_BASE + MODE_STEP * p);
    assign pinHit[p]   = busAddr == ADDR_W'(BANK_BASE + BANK_STEP * p);
    assign latchHit[p] = busAddr == ADDR_W'(BANK_BASE + BANK_STEP * p + LATCH_OFS);
    assign dirHit[p]   = busAddr == ADDR_W'(BANK_BASE + BANK_STEP * p + DIR_OFS);
  end

  always_comb begin
    cmd.sel      = SEL_NONE;
    cmd.portIdx  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (modeHit[p]) begin
        cmd.sel = SEL_MODE;  cmd.portIdx = PORT_IDX_W'(p);
      end else if (dirHit[p]) begin
        cmd.sel = SEL_DIR;   cmd.portIdx = PORT_IDX_W'(p);
      end else if (latchHit[p]) begin
        cmd.sel = SEL_LATCH; cmd.portIdx = PORT_IDX_W'(p);
      end else if (pinHit[p]) begin
        cmd.sel = SEL_PIN;   cmd.portIdx = PORT_IDX_W'(p);
      end
    end
    // pin-state and unmapped addresses never produce a write strobe
    cmd.wrStrobe = busWrEn &&
                   (cmd.sel == SEL_MODE || cmd.sel == SEL_DIR || cmd.sel == SEL_LATCH);
  end
endmodule

// File: rtl/gpio_mux_dpath.sv
module gpio_mux_dpath
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  localparam int TOTAL_W  = NUM_PORTS * PORT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  busCmd_t            cmd,
  input  logic [PORT_W-1:0]  busWrData,
  output logic [PORT_W-1:0]  busRdData,
  input  logic [TOTAL_W-1:0] padIn,
  input  logic [TOTAL_W-1:0] perOut,
  input  logic [TOTAL_W-1:0] perOe,
  output logic [TOTAL_W-1:0] padOut,
  output logic [TOTAL_W-1:0] padOe,
  output logic [TOTAL_W-1:0] perIn
);
  logic [PORT_W-1:0]  modeQ  [NUM_PORTS];
  logic [PORT_W-1:0]  dirQ   [NUM_PORTS];
  logic [PORT_W-1:0]  latchQ [NUM_PORTS];
  logic [TOTAL_W-1:0] syncA, syncB;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hitPort;
    assign hitPort = cmd.wrStrobe && (cmd.portIdx == PORT_IDX_W'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ[p]  <= '0;
        dirQ[p]   <= '1;
        latchQ[p] <= '1;
      end else if (hitPort) begin
        case (cmd.sel)
          SEL_MODE:  modeQ[p]  <= busWrData;
          SEL_DIR:   dirQ[p]   <= busWrData;
          SEL_LATCH: latchQ[p] <= busWrData;
          default:   ;
        endcase
      end
    end

    // peripheral pins pass through; I/O pins: push-pull when dir=0,
    // drive-low-or-release when dir=1
    assign padOe[p*PORT_W +: PORT_W] =
        (modeQ[p] & perOe[p*PORT_W +: PORT_W]) |
        (~modeQ[p] & ~(dirQ[p] & latchQ[p]));
    assign padOut[p*PORT_W +: PORT_W] =
        (modeQ[p] & perOut[p*PORT_W +: PORT_W]) |
        (~modeQ[p] & ~dirQ[p] & latchQ[p]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign perIn = syncB;

  always_comb begin
    busRdData = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (cmd.portIdx == PORT_IDX_W'(p)) begin
        case (cmd.sel)
          SEL_MODE:  busRdData = modeQ[p];
          SEL_DIR:   busRdData = dirQ[p];
          SEL_LATCH: busRdData = latchQ[p];
          SEL_PIN:   busRdData = syncB[p*PORT_W +: PORT_W];
          default:   busRdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int MODE_BASE = 'hF820,
  parameter int MODE_STEP = 2,
  parameter int BANK_BASE = 'hF860,
  parameter int BANK_STEP = 8,
  parameter int LATCH_OFS = 2,
  parameter int DIR_OFS   = 4,
  localparam int TOTAL_W  = NUM_PORTS * PORT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [PORT_W-1:0]  busWrData,
  output logic [PORT_W-1:0]  busRdData,
  input  logic [TOTAL_W-1:0] padIn,
  output logic [TOTAL_W-1:0] padOut,
  output logic [TOTAL_W-1:0] padOe,
  input  logic [TOTAL_W-1:0] perOut,
  input  logic [TOTAL_W-1:0] perOe,
  output logic [TOTAL_W-1:0] perIn
);
  busCmd_t cmd;

  gpio_mux_ctrl #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W),
    .MODE_BASE(MODE_BASE), .MODE_STEP(MODE_STEP),
    .BANK_BASE(BANK_BASE), .BANK_STEP(BANK_STEP),
    .LATCH_OFS(LATCH_OFS), .DIR_OFS(DIR_OFS)
  ) i_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .cmd(cmd)
  );

  gpio_mux_dpath #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)
  ) i_dpath (
    .clk(clk),
    .rstN(rstN),
    .cmd(cmd),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .padIn(padIn),
    .perOut(perOut),
    .perOe(perOe),
    .padOut(padOut),
    .padOe(padOe),
    .perIn(perIn)
  );
endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int MODE_BASE = 'hF820,
  parameter int MODE_STEP = 2,
  parameter int BANK_BASE = 'hF860,
  parameter int BANK_STEP = 8,
  parameter int LATCH_OFS = 2,
  parameter int DIR_OFS   = 4,
  localparam int TOTAL_W  = NUM_PORTS * PORT_W
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [PORT_W-1:0]  busWrData,
  input logic [PORT_W-1:0]  busRdData,
  input logic [TOTAL_W-1:0] padIn,
  input logic [TOTAL_W-1:0] padOe,
  input logic [TOTAL_W-1:0] perIn
);
  logic       isRw, isMapped;
  logic [1:0] age;

  always_comb begin
    isRw     = 1'b0;
    isMapped = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (busAddr == ADDR_W'(MODE_BASE + MODE_STEP * p) ||
          busAddr == ADDR_W'(BANK_BASE + BANK_STEP * p + LATCH_OFS) ||
          busAddr == ADDR_W'(BANK_BASE + BANK_STEP * p + DIR_OFS))
        isRw = 1'b1;
      if (busAddr == ADDR_W'(BANK_BASE + BANK_STEP * p))
        isMapped = 1'b1;
    end
    isMapped = isMapped | isRw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> padOe == '0);

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && isRw) ##1 (busAddr == $past(busAddr)) |-> busRdData == $past(busWrData));

  // R7
  pin_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2) |-> perIn == $past(padIn, 2));

  // R7
  pin_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(BANK_BASE)) |-> busRdData == perIn[PORT_W-1:0]);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped |-> busRdData == '0);
endmodule

bind gpio_mux_port gpio_mux_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W),
  .MODE_BASE(MODE_BASE), .MODE_STEP(MODE_STEP),
  .BANK_BASE(BANK_BASE), .BANK_STEP(BANK_STEP),
  .LATCH_OFS(LATCH_OFS), .DIR_OFS(DIR_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
  .padOe(padOe), .perIn(perIn)
);

// File: tb/test_gpio_mux_port.sv
`timescale 1ns/1ps
module test_gpio_mux_port;
  localparam int W = 8;
  localparam int TW = 24;
  localparam logic [15:0] MODE0 = 16'hF820, MODE1 = 16'hF822;
  localparam logic [15:0] PIN0 = 16'hF860, LAT0 = 16'hF862, DIR0 = 16'hF864;
  localparam logic [15:0] LAT1 = 16'hF86A, PIN2 = 16'hF870, DIR2 = 16'hF874;
  localparam logic [15:0] HOLE = 16'hF830;
  localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_IN = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [W-1:0] busWrData = '0, busRdData;
  logic [TW-1:0] padIn = '0, padOut, padOe, perOut = '0, perOe = '0, perIn;

  always #2.5 clk = ~clk;

  gpio_mux_port i_gpio_mux_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .perOut(perOut), .perOe(perOe),
    .perIn(perIn)
  );

  typedef struct {
    int kind;
    int port;
    logic [W-1:0] exp;
    string tag;
  } item_t;

  item_t expQ[$];
  int checks = 0, errors = 0;
  bit done = 0;

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it = expQ.pop_front();
        case (it.kind)
          K_RD:    act = busRdData;
          K_OUT:   act = padOut[it.port*W +: W];
          K_OE:    act = padOe[it.port*W +: W];
          default: act = perIn[it.port*W +: W];
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wrReg(input logic [15:0] a, input logic [W-1:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic expRd(input logic [15:0] a, input logic [W-1:0] e, input string tag);
    @(posedge clk); #1;
    busAddr = a;
    expQ.push_back('{K_RD, 0, e, tag});
    @(negedge clk);
  endtask

  task automatic expPad(input int kind, input int port, input logic [W-1:0] e, input string tag);
    expQ.push_back('{kind, port, e, tag});
    @(negedge clk);
  endtask

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expPad(K_OE, 0, 8'h00, "R1 oe port0");
    expPad(K_OE, 2, 8'h00, "R1 oe port2");
    expRd(MODE0, 8'h00, "R1 mode0");
    expRd(DIR0, 8'hFF, "R1 dir0");
    expRd(LAT0, 8'hFF, "R1 latch0");
    // R2 writes and readback
    wrReg(MODE1, 8'hA5); expRd(MODE1, 8'hA5, "R2 mode1");
    wrReg(DIR2, 8'h3C);  expRd(DIR2, 8'h3C, "R2 dir2");
    wrReg(LAT1, 8'h5A);  expRd(LAT1, 8'h5A, "R2 latch1");
    // R4 push-pull
    wrReg(DIR0, 8'h00); wrReg(LAT0, 8'hC3);
    expPad(K_OE, 0, 8'hFF, "R4 oe");
    expPad(K_OUT, 0, 8'hC3, "R4 out");
    // R5 open-drain / input
    wrReg(DIR0, 8'hFF); wrReg(LAT0, 8'h0F);
    expPad(K_OE, 0, 8'hF0, "R5 oe");
    expPad(K_OUT, 0, 8'h00, "R5 out");
    // R6 latch read versus pad level
    @(posedge clk); #1 padIn[7:0] = 8'hF0;
    expRd(LAT0, 8'h0F, "R6 latch read");
    expRd(PIN0, 8'hF0, "R7 pin0 read");
    // R3 peripheral handover, mixed per bit
    @(posedge clk); #1 perOut[7:0] = 8'hAA; perOe[7:0] = 8'h55;
    wrReg(MODE0, 8'h0F);
    expPad(K_OE, 0, 8'hF5, "R3 mixed oe");
    expPad(K_OUT, 0, 8'h0A, "R3 mixed out");
    wrReg(MODE0, 8'hFF);
    wrReg(DIR0, 8'h00); wrReg(LAT0, 8'h00);
    expPad(K_OE, 0, 8'h55, "R3 oe ignores dir/latch");
    expPad(K_OUT, 0, 8'hAA, "R3 out ignores dir/latch");
    // R7 synchronizer depth, mode independent
    @(posedge clk); #1 padIn[23:16] = 8'h96;
    expRd(PIN2, 8'h00, "R7 after one edge");
    expRd(PIN2, 8'h96, "R7 after two edges");
    expPad(K_IN, 2, 8'h96, "R7 perIn");
    expRd(PIN0, 8'hF0, "R7 pin read in periph mode");
    // R8 pin-state write has no effect
    wrReg(PIN0, 8'h77);
    expRd(MODE0, 8'hFF, "R8 mode0");
    expRd(DIR0, 8'h00, "R8 dir0");
    expRd(LAT0, 8'h00, "R8 latch0");
    expRd(PIN0, 8'hF0, "R8 pin0");
    // R9 unmapped address
    wrReg(HOLE, 8'hFF);
    expRd(HOLE, 8'h00, "R9 unmapped read");
    expRd(MODE1, 8'hA5, "R9 mode1 untouched");
    expRd(DIR2, 8'h3C, "R9 dir2 untouched");
    repeat (2) @(posedge clk);
    done = 1;
  end

  initial begin : finisher
    fork
      wait (done);
      #50000;
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule